// File: doc/BRIEF.md
# Peak-Tracking Level Estimator and Bit Slicer

This block sits behind the receive filter of a narrowband frequency-shift data receiver. It takes signed samples measured from mid-rail and tracks two levels: the most positive and the most negative excursion of the signal. From these two levels it forms a decision threshold that follows any DC offset. At each mid-bit strobe it slices the sample against that threshold to produce the received bit. A positive excursion reads as 0 and a negative excursion reads as 1.

The level detectors have four behaviours, chosen from a DC-acquire control and a track control:

- **Clamp:** a short burst that pulls both levels toward half the incoming sample.
- **Fast peak:** quick peak capture while acquire is held.
- **Averaging peak:** slow refinement once per bit.
- **Decay:** a hold state in which both levels leak slowly toward zero.

To counter intersymbol interference, the threshold is moved toward the level of the previous decision. The size of that shift depends on the selected filter bandwidth. A powersave input forces the data output low.

Top module: `peak_slicer`

## Requirements
- R1: While reset is asserted, the positive peak, negative peak, threshold and data outputs are all 0.
- R2: A 0-to-1 change of `acq_i` starts clamp mode. Clamp lasts from that cycle through the first `bit_tick_i` cycle after it. In each clamp cycle, both peaks move by floor(((samp>>>1) - peak)/4). If `acq_i` falls, clamp ends at once.
- R3: While `acq_i` is 1 and clamp is not active, the following happens every cycle. The positive peak moves by floor((samp - pos)/4), but only when samp > pos. The negative peak moves by floor((samp - neg)/4), but only when samp < neg.
- R4: While `acq_i` is 1, `track_i` has no effect on the peaks.
- R5: When `acq_i` is 0 and `track_i` is 1, peaks change only in strobe cycles. Let mid = floor((pos+neg)/2). If samp > mid, the positive peak moves by floor((samp - pos)/64). If samp < mid, the negative peak moves by floor((samp - neg)/64). If samp equals mid, nothing changes.
- R6: When `acq_i` and `track_i` are both 0, peaks change only in `bit_tick_i` cycles. In those cycles, each peak moves by floor((0 - peak)/2048).
- R7: In a strobe cycle, the decision becomes 1 if the sample is strictly below the threshold, and 0 otherwise (including equality). The decision is held between strobes and appears on `data_o` from the next cycle.
- R8: The threshold is built from the current peaks, the last decision and `bt_wide_i`, with no register in the path:
  - base = floor((pos+neg)/2).
  - adj = floor((pos-neg)/8) when `bt_wide_i`=0, and floor((pos-neg)/16) when `bt_wide_i`=1.
  - threshold = base - adj after a decision of 1, and base + adj after a decision of 0.
- R9: While `psave_i` is 1, `data_o` is 0. Slicing continues inside the block, and the held decision reappears when `psave_i` returns to 0.
- R10: The positive peak is never below the negative peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low reset |
| samp_i | input | SAMP_W | Signed filtered sample relative to mid-rail |
| strobe_i | input | 1 | Mid-bit slicing strobe |
| bit_tick_i | input | 1 | One pulse per bit period |
| acq_i | input | 1 | DC-acquire control |
| track_i | input | 1 | 1 = keep measuring, 0 = freeze and decay |
| bt_wide_i | input | 1 | Filter setting: 0 = 0.3, 1 = 0.5 |
| psave_i | input | 1 | Receive powersave |
| pos_pk_o | output | SAMP_W | Positive peak level |
| neg_pk_o | output | SAMP_W | Negative peak level |
| thresh_o | output | SAMP_W | Decision threshold |
| data_o | output | 1 | Received bit |

## Verification
The bench raises acquire in the same cycle as a bit tick. A design that ends clamp on that very tick would skip the clamp entirely and enter fast capture with stale peaks. It also drops acquire three cycles into a clamp. A design that kept clamping would pull the peaks to half the sample instead of starting averaging. Sweeping the track control while acquire is high catches a design that lets hold leak into acquisition and freeze or slow the peaks. The bench also places a sample exactly on the threshold at a strobe, which exposes a flipped comparison as a wrong data bit. Runs with both filter settings and with powersave toggling expose a wrong ISI shift size or sign as a wrong threshold value, and a leaky gate as a 1 on the data pin.

// File: rtl/peak_slicer_pkg.sv
package peak_slicer_pkg;

    typedef enum logic [1:0] {
        MODE_CLAMP = 2'd0,
        MODE_FAST  = 2'd1,
        MODE_AVG   = 2'd2,
        MODE_DECAY = 2'd3
    } lvl_mode_e;

    typedef struct packed {
        logic acq_seen;
        logic clamp;
    } ctl_state_t;

endpackage

// File: rtl/ps_mode_ctl.sv
module ps_mode_ctl
    import peak_slicer_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      acq_i,
    input  logic      track_i,
    input  logic      bit_tick_i,
    output lvl_mode_e mode_o
);

    ctl_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d          = st_q;
        rise          = acq_i && !st_q.acq_seen;
        st_d.acq_seen = acq_i;
        st_d.clamp    = acq_i && (rise || (st_q.clamp && !bit_tick_i));
        if (acq_i) begin
            mode_o = (rise || st_q.clamp) ? MODE_CLAMP : MODE_FAST;
        end else begin
            mode_o = track_i ? MODE_AVG : MODE_DECAY;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: clamp never survives a low acquire
    p_clamp_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acq_i |=> !st_q.clamp);

    // R2: clamp lasts no longer than up to the next bit tick
    p_clamp_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.clamp && bit_tick_i) |=> !st_q.clamp);

endmodule

// File: rtl/ps_peak_track.sv
module ps_peak_track
    import peak_slicer_pkg::*;
#(
    parameter int W        = 12,
    parameter int FAST_SH  = 2,
    parameter int AVG_SH   = 6,
    parameter int CLAMP_SH = 2,
    parameter int DECAY_SH = 11
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  lvl_mode_e           mode_i,
    input  logic signed [W-1:0] samp_i,
    input  logic                strobe_i,
    input  logic                bit_tick_i,
    output logic signed [W-1:0] pos_o,
    output logic signed [W-1:0] neg_o
);

    localparam int EW = W + 1;

    typedef struct packed {
        logic [W-1:0] pos;
        logic [W-1:0] neg;
    } pk_state_t;

    pk_state_t st_d, st_q;

    logic signed [W-1:0]  pos_s, neg_s, half;
    logic signed [EW-1:0] samp_x, mid;

    // move cur toward tgt by floor((tgt-cur)/2^sh)
    function automatic logic signed [W-1:0] nudge(
        input logic signed [W-1:0] cur,
        input logic signed [W-1:0] tgt,
        input int                  sh
    );
        logic signed [EW-1:0] err, step, sum;
        err  = $signed({tgt[W-1], tgt}) - $signed({cur[W-1], cur});
        step = err >>> sh;
        sum  = $signed({cur[W-1], cur}) + step;
        return sum[W-1:0];
    endfunction

    assign pos_s = $signed(st_q.pos);
    assign neg_s = $signed(st_q.neg);

    always_comb begin
        st_d   = st_q;
        half   = samp_i >>> 1;
        samp_x = {samp_i[W-1], samp_i};
        mid    = ($signed({pos_s[W-1], pos_s}) + $signed({neg_s[W-1], neg_s})) >>> 1;
        case (mode_i)
            MODE_CLAMP: begin
                st_d.pos = nudge(pos_s, half, CLAMP_SH);
                st_d.neg = nudge(neg_s, half, CLAMP_SH);
            end
            MODE_FAST: begin
                if (samp_i > pos_s) st_d.pos = nudge(pos_s, samp_i, FAST_SH);
                if (samp_i < neg_s) st_d.neg = nudge(neg_s, samp_i, FAST_SH);
            end
            MODE_AVG: begin
                if (strobe_i) begin
                    if (samp_x > mid) begin
                        st_d.pos = nudge(pos_s, samp_i, AVG_SH);
                    end else if (samp_x < mid) begin
                        st_d.neg = nudge(neg_s, samp_i, AVG_SH);
                    end
                end
            end
            default: begin
                if (bit_tick_i) begin
                    st_d.pos = nudge(pos_s, '0, DECAY_SH);
                    st_d.neg = nudge(neg_s, '0, DECAY_SH);
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o = pos_s;
    assign neg_o = neg_s;

    // R10: the two levels never cross
    p_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_s >= neg_s);

    // R3: fast capture only widens the span
    p_fast_widen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_FAST) |=> (pos_s >= $past(pos_s) && neg_s <= $past(neg_s)));

    // R5: averaging acts only on strobe cycles
    p_avg_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_AVG && !strobe_i) |=> $stable(st_q));

    // R6: decay acts only on bit ticks
    p_decay_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_DECAY && !bit_tick_i) |=> $stable(st_q));

endmodule

// File: rtl/ps_thresh_slice.sv
module ps_thresh_slice #(
    parameter int W         = 12,
    parameter int NARROW_SH = 3,
    parameter int WIDE_SH   = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic signed [W-1:0] pos_i,
    input  logic signed [W-1:0] neg_i,
    input  logic signed [W-1:0] samp_i,
    input  logic                strobe_i,
    input  logic                bt_wide_i,
    output logic signed [W-1:0] thresh_o,
    output logic                dec_o
);

    localparam int EW = W + 1;

    logic                 dec_d, dec_q;
    logic signed [EW-1:0] pos_x, neg_x, samp_x, base, span, adj, thr_x;

    always_comb begin
        pos_x  = {pos_i[W-1], pos_i};
        neg_x  = {neg_i[W-1], neg_i};
        samp_x = {samp_i[W-1], samp_i};
        base   = (pos_x + neg_x) >>> 1;
        span   = pos_x - neg_x;
        adj    = bt_wide_i ? (span >>> WIDE_SH) : (span >>> NARROW_SH);
        thr_x  = dec_q ? (base - adj) : (base + adj);
        dec_d  = strobe_i ? (samp_x < thr_x) : dec_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dec_q <= 1'b0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign thresh_o = thr_x[W-1:0];
    assign dec_o    = dec_q;

    // R7: decision only changes on a strobe
    p_dec_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> $stable(dec_q));

    // R8: threshold stays between the two peaks
    p_thr_inside_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (thresh_o <= pos_i) && (thresh_o >= neg_i));

endmodule

// File: rtl/peak_slicer.sv
module peak_slicer
    import peak_slicer_pkg::*;
#(
    parameter int SAMP_W           = 12,
    parameter int FAST_SHIFT       = 2,
    parameter int AVG_SHIFT        = 6,
    parameter int CLAMP_SHIFT      = 2,
    parameter int DECAY_SHIFT      = 11,
    parameter int NARROW_ISI_SHIFT = 3,
    parameter int WIDE_ISI_SHIFT   = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic signed [SAMP_W-1:0] samp_i,
    input  logic                     strobe_i,
    input  logic                     bit_tick_i,
    input  logic                     acq_i,
    input  logic                     track_i,
    input  logic                     bt_wide_i,
    input  logic                     psave_i,
    output logic signed [SAMP_W-1:0] pos_pk_o,
    output logic signed [SAMP_W-1:0] neg_pk_o,
    output logic signed [SAMP_W-1:0] thresh_o,
    output logic                     data_o
);

    lvl_mode_e mode;
    logic      dec;

    ps_mode_ctl i_ctl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .acq_i      (acq_i),
        .track_i    (track_i),
        .bit_tick_i (bit_tick_i),
        .mode_o     (mode)
    );

    ps_peak_track #(
        .W        (SAMP_W),
        .FAST_SH  (FAST_SHIFT),
        .AVG_SH   (AVG_SHIFT),
        .CLAMP_SH (CLAMP_SHIFT),
        .DECAY_SH (DECAY_SHIFT)
    ) i_trk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mode),
        .samp_i     (samp_i),
        .strobe_i   (strobe_i),
        .bit_tick_i (bit_tick_i),
        .pos_o      (pos_pk_o),
        .neg_o      (neg_pk_o)
    );

    ps_thresh_slice #(
        .W         (SAMP_W),
        .NARROW_SH (NARROW_ISI_SHIFT),
        .WIDE_SH   (WIDE_ISI_SHIFT)
    ) i_slc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pos_i     (pos_pk_o),
        .neg_i     (neg_pk_o),
        .samp_i    (samp_i),
        .strobe_i  (strobe_i),
        .bt_wide_i (bt_wide_i),
        .thresh_o  (thresh_o),
        .dec_o     (dec)
    );

    assign data_o = dec && !psave_i;

    // R9: a held 1 reappears one cycle after powersave drops with no strobe
    p_psave_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psave_i && dec && !strobe_i) ##1 !psave_i |-> data_o);

endmodule

// File: tb/test_peak_slicer.sv
module test_peak_slicer;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [11:0] samp = '0;
    logic               stb = 1'b0, tick = 1'b0, acq = 1'b0, trk = 1'b0;
    logic               btw = 1'b0, ps = 1'b0;
    logic signed [11:0] pos_w, neg_w, thr_w;
    logic               data_w;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int pos;
        int neg;
        int thr;
        bit d;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    string cur_tag = "R1";

    int       m_pos = 0, m_neg = 0;
    bit       m_dec = 1'b0, m_acq_prev = 1'b0, m_clamp = 1'b0;
    bit [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    peak_slicer i_peak_slicer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .samp_i     (samp),
        .strobe_i   (stb),
        .bit_tick_i (tick),
        .acq_i      (acq),
        .track_i    (trk),
        .bt_wide_i  (btw),
        .psave_i    (ps),
        .pos_pk_o   (pos_w),
        .neg_pk_o   (neg_w),
        .thresh_o   (thr_w),
        .data_o     (data_w)
    );

    function automatic int nud(input int c, input int t, input int sh);
        return c + ((t - c) >>> sh);
    endfunction

    // R8 reference threshold
    function automatic int thr_of(input int p, input int n, input bit d, input bit w);
        int b;
        int a;
        b = (p + n) >>> 1;
        a = (p - n) >>> (w ? 4 : 3);
        return d ? (b - a) : (b + a);
    endfunction

    // driver: one cycle of stimulus plus the expected state after the edge
    task automatic step(input int s, input bit st, input bit tk, input bit aq,
                        input bit tr, input bit bw, input bit pw);
        int  thr;
        int  np;
        int  nn;
        int  mid;
        bit  rise;
        bit  clamp_now;
        exp_t e;
        @(negedge clk);
        samp = 12'(s); stb = st; tick = tk; acq = aq; trk = tr; btw = bw; ps = pw;
        thr       = thr_of(m_pos, m_neg, m_dec, bw);
        rise      = aq && !m_acq_prev;
        clamp_now = aq && (rise || m_clamp);
        np = m_pos;
        nn = m_neg;
        if (aq) begin
            if (clamp_now) begin
                np = nud(m_pos, s >>> 1, 2);
                nn = nud(m_neg, s >>> 1, 2);
            end else begin
                if (s > m_pos) np = nud(m_pos, s, 2);
                if (s < m_neg) nn = nud(m_neg, s, 2);
            end
        end else if (tr) begin
            if (st) begin
                mid = (m_pos + m_neg) >>> 1;
                if (s > mid) np = nud(m_pos, s, 6);
                else if (s < mid) nn = nud(m_neg, s, 6);
            end
        end else if (tk) begin
            np = nud(m_pos, 0, 11);
            nn = nud(m_neg, 0, 11);
        end
        if (st) m_dec = (s < thr);
        m_clamp    = aq && (rise || (m_clamp && !tk));
        m_acq_prev = aq;
        m_pos = np;
        m_neg = nn;
        e.pos = m_pos;
        e.neg = m_neg;
        e.thr = thr_of(m_pos, m_neg, m_dec, bw);
        e.d   = pw ? 1'b0 : m_dec;
        exp_q.push_back(e);
        tag_q.push_back(cur_tag);
    endtask

    task automatic send_bits(input int nbits, input bit rnd, input int off, input int amp,
                             input bit aq, input bit tr, input bit bw, input bit pw,
                             input bit trk_toggle);
        for (int i = 0; i < nbits; i++) begin
            bit b;
            bit t;
            if (rnd) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                b = lfsr[0];
            end else begin
                b = (i % 4) < 2;
            end
            t = trk_toggle ? i[0] : tr;
            for (int ph = 0; ph < 8; ph++) begin
                int d;
                int lv;
                d  = (ph > 4) ? (ph - 4) : (4 - ph);
                lv = amp - 40 * d;
                step(off + (b ? -lv : lv), ph == 4, ph == 0, aq, t, bw, pw);
            end
        end
    endtask

    // monitor: compares each expected item after its edge
    initial begin
        forever begin
            exp_t  e;
            string t;
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (int'(pos_w) != e.pos || int'(neg_w) != e.neg ||
                    int'(thr_w) != e.thr || data_w != e.d) begin
                    errors++;
                    $display("FAIL %s: pos %0d exp %0d, neg %0d exp %0d, thr %0d exp %0d, data %0b exp %0b",
                             t, pos_w, e.pos, neg_w, e.neg, thr_w, e.thr, data_w, e.d);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run incomplete, actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (pos_w != 0 || neg_w != 0 || thr_w != 0 || data_w != 0) begin
            errors++;
            $display("FAIL R1: pos %0d neg %0d thr %0d data %0b exp all 0", pos_w, neg_w, thr_w, data_w);
        end
        rst_n = 1'b1;

        cur_tag = "R5 averaging from zero";
        send_bits(4, 1'b0, 150, 600, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cur_tag = "R2 clamp after rise on tick";
        send_bits(1, 1'b0, 150, 600, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        cur_tag = "R3 fast peak capture";
        send_bits(16, 1'b0, 150, 600, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        cur_tag = "R4 track ignored in acquire";
        send_bits(8, 1'b0, 150, 900, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        cur_tag = "R5 averaging random data";
        send_bits(40, 1'b1, 100, 700, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        cur_tag = "R8 wide setting";
        send_bits(24, 1'b1, 100, 700, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        cur_tag = "R9 powersave";
        send_bits(10, 1'b1, -80, 700, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        cur_tag = "R9 powersave release";
        send_bits(4, 1'b1, -80, 700, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

        // R2: acquire dropped inside the clamp window
        cur_tag = "R2 clamp cut by acquire drop";
        step(1200, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        step(1200, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        step(1200, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        step(1200, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        step(1200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        cur_tag = "R3 fast after clamp, then R10 order";
        send_bits(12, 1'b1, 0, 800, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // R7: sample exactly on the threshold, then one below
        cur_tag = "R7 equal to threshold slices 0";
        step(thr_of(m_pos, m_neg, m_dec, 1'b0), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cur_tag = "R7 below threshold slices 1";
        step(thr_of(m_pos, m_neg, m_dec, 1'b0) - 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cur_tag = "R8 narrow shift after a 1";
        step(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        cur_tag = "R6 decay ignores samples";
        send_bits(220, 1'b1, 300, 1500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        repeat (4) @(posedge clk);
        #6;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule